// File: doc/BRIEF.md
# Cascadable Binary Decoder with Mixed-Polarity Enables

The block turns a binary select code into a one-of-many output code with active-low outputs. Its basic unit is a 3-to-8 decoder. The unit has three enables: one active-high and two active-low. All three must be asserted before any output goes low. While the unit is disabled, all eight outputs stay high.

The top level joins two units into a 4-to-16 decoder with no extra gating. The most significant select bit goes to an active-low enable of the lower unit and to the active-high enable of the upper unit. An active-low global enable goes to the remaining active-low enables. The lower unit covers output indices 0 to 7 and the upper unit covers 8 to 15. The whole block is combinational and has no state.

Top module: `bin_dec_cascade`

## Requirements
- R1: A decoder unit is enabled only when its active-high enable is 1 and both of its active-low enables are 0. Any other enable combination disables it.
- R2: While a unit is enabled, output bit i of that unit is 0 exactly when the 3-bit select equals i, and every other output bit is 1.
- R3: While a unit is disabled, all eight of its outputs are 1, whatever the select value.
- R4: When the global enable `en_ni` is 1, all 16 bits of `y_no` are 1 for every value of `sel_i`.
- R5: When `en_ni` is 0, bit k of `y_no` is 0 exactly when k equals `sel_i`. Here k = `sel_i[3]`*8 + `sel_i[2:0]`.
- R6: Bits [7:0] of `y_no` can go low only while `sel_i[3]` is 0, and bits [15:8] only while `sel_i[3]` is 1. The two halves are never active together.
- R7: At most one bit of `y_no` is 0 at any time. The outputs follow the inputs in the same cycle, with no clocked state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sel_i | input | 4 | Binary select code; bit 3 chooses the unit |
| en_ni | input | 1 | Global enable, active low |
| y_no | output | 16 | Decoded one-hot outputs, active low |

## Verification
Two functions act in the same cycle: bit 3 of the select turns one unit on and, at the same moment, turns the other unit off. The bench provokes this by stepping the select across every boundary, including the 7-to-8 and 15-to-0 wraps. It does so with the global enable held both asserted and deasserted. After each step it counts the low bits on the 16-bit bus and checks the whole word against an index computed arithmetically. A standalone unit is also swept across all eight enable combinations and all eight select values, so that the enable polarity of each input is judged on its own.

// File: rtl/bin_dec_pkg.sv
package bin_dec_pkg;

  localparam int unsigned UNIT_SEL_W = 3;
  localparam int unsigned UNIT_OUT_W = 1 << UNIT_SEL_W;
  localparam int unsigned CASC_SEL_W = UNIT_SEL_W + 1;
  localparam int unsigned CASC_OUT_W = 1 << CASC_SEL_W;

  // enable triple of one unit: one active-high, two active-low
  typedef struct packed {
    logic hi;
    logic lo_a_n;
    logic lo_b_n;
  } dec_en_t;

endpackage

// File: rtl/bin_dec_en_combine.sv
module bin_dec_en_combine
  import bin_dec_pkg::*;
(
  input  dec_en_t en_i,
  output logic    en_o
);

  assign en_o = en_i.hi & ~en_i.lo_a_n & ~en_i.lo_b_n;

endmodule

// File: rtl/bin_dec_onehot.sv
module bin_dec_onehot #(
  parameter int unsigned SEL_W = 3,
  localparam int unsigned OUT_W = 1 << SEL_W
) (
  input  logic [SEL_W-1:0] sel_i,
  input  logic             en_i,
  output logic [OUT_W-1:0] y_no
);

  for (genvar i = 0; i < OUT_W; i++) begin : g_term
    assign y_no[i] = ~(en_i && (sel_i == SEL_W'(i)));
  end

  always_comb begin
    if (!en_i) begin
      AST_DIS_ALL_HIGH: assert (&y_no); // R3
    end else begin
      AST_EN_ONE_LOW: assert (($countones(~y_no) == 1) && !y_no[sel_i]); // R2
    end
  end

endmodule

// File: rtl/bin_dec_unit.sv
module bin_dec_unit
  import bin_dec_pkg::*;
(
  input  logic [UNIT_SEL_W-1:0] sel_i,
  input  logic                  g_hi_i,
  input  logic                  g_lo_a_ni,
  input  logic                  g_lo_b_ni,
  output logic [UNIT_OUT_W-1:0] y_no
);

  dec_en_t en_bundle;
  logic    en_q;

  assign en_bundle = '{hi: g_hi_i, lo_a_n: g_lo_a_ni, lo_b_n: g_lo_b_ni};

  bin_dec_en_combine u_en (
    .en_i (en_bundle),
    .en_o (en_q)
  );

  bin_dec_onehot #(.SEL_W(UNIT_SEL_W)) u_core (
    .sel_i (sel_i),
    .en_i  (en_q),
    .y_no  (y_no)
  );

  always_comb begin
    if (!g_hi_i || g_lo_a_ni || g_lo_b_ni) begin
      AST_ANY_EN_OFF_IDLE: assert (&y_no); // R1
    end
  end

endmodule

// File: rtl/bin_dec_cascade.sv
module bin_dec_cascade
  import bin_dec_pkg::*;
(
  input  logic [CASC_SEL_W-1:0] sel_i,
  input  logic                  en_ni,
  output logic [CASC_OUT_W-1:0] y_no
);

  localparam int unsigned N_UNITS = 2;

  logic top_bit;
  assign top_bit = sel_i[CASC_SEL_W-1];

  for (genvar u = 0; u < N_UNITS; u++) begin : g_unit
    logic g_hi, g_lo_a_n, g_lo_b_n;
    if (u == 0) begin : g_low
      // top bit steers through an active-low enable
      assign g_hi     = 1'b1;
      assign g_lo_a_n = top_bit;
      assign g_lo_b_n = en_ni;
    end else begin : g_high
      // top bit steers through the active-high enable
      assign g_hi     = top_bit;
      assign g_lo_a_n = en_ni;
      assign g_lo_b_n = en_ni;
    end

    bin_dec_unit u_dec (
      .sel_i     (sel_i[UNIT_SEL_W-1:0]),
      .g_hi_i    (g_hi),
      .g_lo_a_ni (g_lo_a_n),
      .g_lo_b_ni (g_lo_b_n),
      .y_no      (y_no[u*UNIT_OUT_W +: UNIT_OUT_W])
    );
  end

  always_comb begin
    AST_AT_MOST_ONE_LOW: assert ($countones(~y_no) <= 1); // R7
    AST_HALVES_EXCL: assert ((&y_no[UNIT_OUT_W-1:0]) || (&y_no[CASC_OUT_W-1:UNIT_OUT_W])); // R6
    if (en_ni) begin
      AST_GLOBAL_OFF: assert (&y_no); // R4
    end else begin
      AST_SEL_LOW: assert (!y_no[sel_i]); // R5
    end
  end

endmodule

// File: tb/bin_dec_cascade_tb.sv
module bin_dec_cascade_tb_top;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk = ~clk;

  logic [3:0]  sel;
  logic        en_n;
  logic [15:0] y_n;

  logic [2:0]  u_sel;
  logic        u_hi, u_lo_a_n, u_lo_b_n;
  logic [7:0]  u_y_n;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  bin_dec_cascade dut_i (
    .sel_i (sel),
    .en_ni (en_n),
    .y_no  (y_n)
  );

  bin_dec_unit unit_i (
    .sel_i     (u_sel),
    .g_hi_i    (u_hi),
    .g_lo_a_ni (u_lo_a_n),
    .g_lo_b_ni (u_lo_b_n),
    .y_no      (u_y_n)
  );

  task automatic chk16(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic chk8(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic apply_top(input logic [3:0] s, input logic e_n);
    logic [15:0] exp;
    int k;
    int lows;
    @(posedge clk);
    sel = s;
    en_n = e_n;
    #5;
    exp = '1;
    k = int'(s[3]) * 8 + int'(s[2:0]);
    if (!e_n) exp[k] = 1'b0;
    chk16(e_n ? "R4" : "R5", y_n, exp);
    lows = 0;
    for (int b = 0; b < 16; b++) if (y_n[b] == 1'b0) lows++;
    checks++;
    if (lows > 1) begin
      failures++;
      $display("FAIL R7 act=%0d exp<=1", lows);
    end
    checks++;
    if ((s[3] && !(&y_n[7:0])) || (!s[3] && !(&y_n[15:8]))) begin
      failures++;
      $display("FAIL R6 act=%h exp=half_idle", y_n);
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stim
    sel = '0; en_n = 1'b1;
    u_sel = '0; u_hi = 1'b0; u_lo_a_n = 1'b1; u_lo_b_n = 1'b1;
    repeat (3) @(posedge clk);
    #5;
    chk16("R4 reset", y_n, 16'hFFFF);
    chk8("R3 reset", u_y_n, 8'hFF);
    rst_ni = 1'b1;

    // unit: all enable combinations x all selects (R1, R2, R3)
    for (int e = 0; e < 8; e++) begin
      for (int s = 0; s < 8; s++) begin
        logic [7:0] exp;
        logic on;
        @(posedge clk);
        u_hi = e[2]; u_lo_a_n = e[1]; u_lo_b_n = e[0];
        u_sel = 3'(s);
        #5;
        on = e[2] && !e[1] && !e[0];
        exp = '1;
        if (on) exp[s] = 1'b0;
        chk8(on ? "R2" : (e[2] ? "R1" : "R3"), u_y_n, exp);
      end
    end

    // cascade: full sweep, both enable levels
    for (int e = 0; e < 2; e++)
      for (int s = 0; s < 16; s++)
        apply_top(4'(s), 1'(e));

    // unit swap transitions with enable held
    apply_top(4'd7, 1'b0);
    apply_top(4'd8, 1'b0);
    apply_top(4'd15, 1'b0);
    apply_top(4'd0, 1'b0);
    apply_top(4'd8, 1'b1);
    apply_top(4'd7, 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule